// File: doc/BRIEF.md
# Multi-channel PWM bank with buffered duty updates

This block drives a group of pulse outputs from a single free-running period counter. Each channel holds two edge counts: one sets where the pulse starts, the other where it stops. A per-channel invert bit flips the output. Software programs the block through a small register interface in the style of APB. A write completes in the access phase, and reads are combinational on the address.

Two build-time masks choose each channel's structure. A channel in the buffer mask gets an extra active copy of both edge registers. While the runtime sync bit is set, those copies reload only when the period counter wraps, so a pair of edges written mid-period never yields a torn pulse. While the sync bit is clear, a buffered channel behaves like an unbuffered one. A channel in the density mask does not compare against the counter. It adds its start value to an accumulator every clock and outputs the carry. The result is the densest pulse train whose average equals value / 2^CNT_W, with much lower ripple than a PWM output at the same duty.

Top module: `pwm_bank`

## Requirements
- R1: After a synchronous active-low reset, every output is low, the period register reads all ones in its CNT_W bits, and the control, invert and all edge registers read zero.
- R2: A write takes place on a clock edge with psel, penable and pwrite high. Word addresses (paddr/4) are: word 0 period, word 1 control (bit 0 = sync), word 2 invert (bit c = channel c), word 4+2c start edge of channel c, word 5+2c stop edge of channel c. Reads return the last written value, with bits above each field zero, and any other word reads zero.
- R3: The period counter runs 0, 1, … up to the period value and then returns to 0. It wraps on any cycle where it is at or above the period value, so a stable period P repeats every P+1 cycles.
- R4: A PWM channel is high while start ≤ count < stop, using its effective edge values; when start ≥ stop it never goes high.
- R5: A set invert bit makes that channel's output the complement of its uninverted value.
- R6: On an unbuffered channel, a written edge value is in effect on the cycle after the write, whatever the sync bit says.
- R7: On a buffered channel with sync set, written edge values take effect only on the clock edge where the counter wraps, and from count 0 of the next period. Until then the previous values stay in force.
- R8: On a buffered channel with sync clear, writes take effect on the next cycle as in R6, and the active copies follow them, so setting sync later keeps the most recent values.
- R9: A density channel adds its start value to a CNT_W-bit accumulator every clock, and its output is the registered carry. Over any 2^CNT_W consecutive cycles with a constant value V it is high for exactly V cycles, and with V = 0 it stays low.
- R10: A density channel's output does not depend on its stop register or on the period counter.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| psel | input | 1 | Register select |
| penable | input | 1 | Access phase strobe |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | ADDR_W | Byte address, word aligned |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data for paddr |
| pwm_out | output | NCH | One output per channel |

## Verification
If the counter or an active copy goes wrong, an output changes in the wrong cycle within one period. The wrong cycle is either the cycle after a write or the first count after a wrap, so the bench compares every output on every cycle, not just averages. A fault in a buffered channel's reload shows as an edge that moves in the middle of a period. A fault in the accumulator changes the number of high cycles in a 2^CNT_W window, which is counted exactly. Faults in register decoding show up on the next read, or as a write that lands in the wrong channel and changes that channel's output.

// File: rtl/pwm_pkg.sv
// Package: shared register word map and decode kinds for the PWM bank.
// Assumes word addressing (byte address / 4) on the register interface.
package pwm_pkg;
    localparam int WORD_PERIOD  = 0;
    localparam int WORD_CTRL    = 1;
    localparam int WORD_INVERT  = 2;
    localparam int WORD_CH_BASE = 4;

    typedef enum logic [2:0] {
        DEC_NONE,
        DEC_PERIOD,
        DEC_CTRL,
        DEC_INVERT,
        DEC_START,
        DEC_STOP
    } reg_kind_e;
endpackage

// File: rtl/pwm_regs.sv
// Register file: decodes word addresses, holds period, sync bit, invert mask
// and the written (staged) edge values of every channel.
// Assumes CNT_W <= 32, NCH <= 32 and enough address bits for 4 + 2*NCH words.
module pwm_regs #(
    parameter int NCH    = 16,
    parameter int CNT_W  = 16,
    parameter int ADDR_W = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       psel,
    input  logic                       penable,
    input  logic                       pwrite,
    input  logic [ADDR_W-1:0]          paddr,
    input  logic [31:0]                pwdata,
    output logic [31:0]                prdata,
    output logic [CNT_W-1:0]           period,
    output logic                       sync_en,
    output logic [NCH-1:0]             invert,
    output logic [NCH-1:0][CNT_W-1:0]  start_stage,
    output logic [NCH-1:0][CNT_W-1:0]  stop_stage
);
    import pwm_pkg::*;

    localparam int WORD_W = ADDR_W - 2;
    localparam int CH_W   = (NCH > 1) ? $clog2(NCH) : 1;
    localparam logic [WORD_W-1:0] W_PERIOD = WORD_W'(WORD_PERIOD);
    localparam logic [WORD_W-1:0] W_CTRL   = WORD_W'(WORD_CTRL);
    localparam logic [WORD_W-1:0] W_INVERT = WORD_W'(WORD_INVERT);
    localparam logic [WORD_W-1:0] W_BASE   = WORD_W'(WORD_CH_BASE);
    localparam logic [WORD_W-1:0] W_END    = WORD_W'(WORD_CH_BASE + 2 * NCH);

    logic [WORD_W-1:0] word;
    logic [WORD_W-1:0] ch_off;
    logic [CH_W-1:0]   ch;
    reg_kind_e         kind;
    logic              wr;
    logic              unused_bus;

    assign word       = paddr[ADDR_W-1:2];
    assign ch_off     = word - W_BASE;
    assign wr         = psel && penable && pwrite;
    assign unused_bus = ^{paddr[1:0], pwdata};

    // Classify the addressed word and pick the channel it belongs to.
    always_comb begin
        kind = DEC_NONE;
        ch   = ch_off[CH_W:1];
        if (word == W_PERIOD)                      kind = DEC_PERIOD;
        else if (word == W_CTRL)                   kind = DEC_CTRL;
        else if (word == W_INVERT)                 kind = DEC_INVERT;
        else if (word >= W_BASE && word < W_END)   kind = ch_off[0] ? DEC_STOP : DEC_START;
    end

    // Store register writes; reset puts the period at its maximum.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            period      <= '1;
            sync_en     <= 1'b0;
            invert      <= '0;
            start_stage <= '0;
            stop_stage  <= '0;
        end else if (wr) begin
            case (kind)
                DEC_PERIOD: period          <= pwdata[CNT_W-1:0];
                DEC_CTRL:   sync_en         <= pwdata[0];
                DEC_INVERT: invert          <= pwdata[NCH-1:0];
                DEC_START:  start_stage[ch] <= pwdata[CNT_W-1:0];
                DEC_STOP:   stop_stage[ch]  <= pwdata[CNT_W-1:0];
                default: ;
            endcase
        end
    end

    // Return the addressed field, zero above it and for unmapped words.
    always_comb begin
        prdata = '0;
        case (kind)
            DEC_PERIOD: prdata[CNT_W-1:0] = period;
            DEC_CTRL:   prdata[0]         = sync_en;
            DEC_INVERT: prdata[NCH-1:0]   = invert;
            DEC_START:  prdata[CNT_W-1:0] = start_stage[ch];
            DEC_STOP:   prdata[CNT_W-1:0] = stop_stage[ch];
            default: ;
        endcase
    end

    assert_period_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && kind == DEC_PERIOD) |=> period == $past(pwdata[CNT_W-1:0]));

    assert_sync_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && kind == DEC_CTRL) |=> sync_en == $past(pwdata[0]));
endmodule

// File: rtl/pwm_timebase.sv
// Shared period counter: counts from 0 to the period value and wraps.
// Assumes the period may change at any time; a count above it wraps at once.
module pwm_timebase #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] period,
    output logic [CNT_W-1:0] count,
    output logic             wrap
);
    assign wrap = (count >= period);

    // Advance the count, returning to zero on the wrap cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)    count <= '0;
        else if (wrap) count <= '0;
        else           count <= count + 1'b1;
    end

    assert_wrap_to_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        wrap |=> count == '0);

    assert_count_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> count <= $past(period));
endmodule

// File: rtl/pwm_channel.sv
// One output channel. HAS_BUF adds active copies of both edges that reload
// on wrap while sync is set; IS_DENSITY swaps the edge comparator for a
// first-order accumulator whose carry is the output.
// Assumes staged edges come straight from the register file.
module pwm_channel #(
    parameter int CNT_W      = 16,
    parameter bit HAS_BUF    = 1'b0,
    parameter bit IS_DENSITY = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] count,
    input  logic             wrap,
    input  logic             sync_en,
    input  logic             invert,
    input  logic [CNT_W-1:0] start_stage,
    input  logic [CNT_W-1:0] stop_stage,
    output logic             pwm_o
);
    logic [CNT_W-1:0] start_eff;
    logic [CNT_W-1:0] stop_eff;
    logic             raw;

    generate
        if (HAS_BUF) begin : g_buf
            logic [CNT_W-1:0] start_act;
            logic [CNT_W-1:0] stop_act;

            // Reload active edges on wrap in sync mode, every cycle otherwise.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    start_act <= '0;
                    stop_act  <= '0;
                end else if (!sync_en || wrap) begin
                    start_act <= start_stage;
                    stop_act  <= stop_stage;
                end
            end

            assign start_eff = sync_en ? start_act : start_stage;
            assign stop_eff  = sync_en ? stop_act  : stop_stage;

            assert_hold_until_wrap_R7: assert property (@(posedge clk) disable iff (!rst_n)
                (sync_en && !wrap) |=> ($stable(start_act) && $stable(stop_act)));

            assert_load_at_wrap_R7: assert property (@(posedge clk) disable iff (!rst_n)
                (sync_en && wrap) |=> (start_act == $past(start_stage) && stop_act == $past(stop_stage)));

            assert_track_when_async_R8: assert property (@(posedge clk) disable iff (!rst_n)
                !sync_en |=> (start_act == $past(start_stage) && stop_act == $past(stop_stage)));
        end else begin : g_direct
            logic unused_sync;
            assign unused_sync = sync_en ^ wrap;
            assign start_eff   = start_stage;
            assign stop_eff    = stop_stage;
        end

        if (IS_DENSITY) begin : g_density
            logic [CNT_W-1:0] acc;
            logic             carry_q;
            logic [CNT_W:0]   sum;
            logic             unused_pwm;

            assign sum        = {1'b0, acc} + {1'b0, start_eff};
            assign unused_pwm = ^{count, stop_eff};

            // Accumulate the density value and register the carry out.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    acc     <= '0;
                    carry_q <= 1'b0;
                end else begin
                    acc     <= sum[CNT_W-1:0];
                    carry_q <= sum[CNT_W];
                end
            end

            assign raw = carry_q;

            assert_density_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
                (start_eff == '0) |=> !carry_q);
        end else begin : g_pwm
            assign raw = (count >= start_eff) && (count < stop_eff);

            assert_empty_window_R4: assert property (@(posedge clk) disable iff (!rst_n)
                (start_eff >= stop_eff) |-> !raw);
        end
    endgenerate

    assign pwm_o = raw ^ invert;

    assert_invert_R5: assert property (@(posedge clk) disable iff (!rst_n)
        invert |-> (pwm_o != raw));
endmodule

// File: rtl/pwm_bank.sv
// Top level: register file, shared time base and NCH channels whose
// buffering and density variants come from the two build-time masks.
// Assumes a single clock domain and synchronous active-low reset.
module pwm_bank #(
    parameter int             NCH          = 16,
    parameter int             CNT_W        = 16,
    parameter int             ADDR_W       = 8,
    parameter logic [NCH-1:0] BUF_MASK     = '0,
    parameter logic [NCH-1:0] DENSITY_MASK = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [ADDR_W-1:0] paddr,
    input  logic [31:0]       pwdata,
    output logic [31:0]       prdata,
    output logic [NCH-1:0]    pwm_out
);
    logic [CNT_W-1:0]          period;
    logic                      sync_en;
    logic [NCH-1:0]            invert;
    logic [NCH-1:0][CNT_W-1:0] start_stage;
    logic [NCH-1:0][CNT_W-1:0] stop_stage;
    logic [CNT_W-1:0]          count;
    logic                      wrap;

    pwm_regs #(.NCH(NCH), .CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable),
        .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
        .period(period), .sync_en(sync_en), .invert(invert),
        .start_stage(start_stage), .stop_stage(stop_stage)
    );

    pwm_timebase #(.CNT_W(CNT_W)) u_timebase (
        .clk(clk), .rst_n(rst_n), .period(period), .count(count), .wrap(wrap)
    );

    generate
        for (genvar c = 0; c < NCH; c++) begin : g_ch
            pwm_channel #(
                .CNT_W(CNT_W), .HAS_BUF(BUF_MASK[c]), .IS_DENSITY(DENSITY_MASK[c])
            ) u_ch (
                .clk(clk), .rst_n(rst_n), .count(count), .wrap(wrap),
                .sync_en(sync_en), .invert(invert[c]),
                .start_stage(start_stage[c]), .stop_stage(stop_stage[c]),
                .pwm_o(pwm_out[c])
            );
        end
    endgenerate
endmodule

// File: tb/pwm_bank_bench.sv
// Bench: four channels (plain PWM, buffered PWM, density, buffered density),
// a cycle-level reference model and per-cycle output comparison.
module pwm_bank_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NCH = 4;
    localparam int CW  = 8;
    localparam int AW  = 8;
    localparam logic [NCH-1:0] BUFM = 4'b1010;
    localparam logic [NCH-1:0] DENM = 4'b1100;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
    logic [AW-1:0] paddr = '0;
    logic [31:0] pwdata = '0;
    logic [31:0] prdata;
    logic [NCH-1:0] pwm_out;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;
    bit cmp_on   = 1'b0;

    pwm_bank #(.NCH(NCH), .CNT_W(CW), .ADDR_W(AW), .BUF_MASK(BUFM), .DENSITY_MASK(DENM))
    u_pwm_bank (.clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
                .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .pwm_out(pwm_out));

    always #(CLK_PERIOD / 2) clk = ~clk;

    // Reference model state
    logic [CW-1:0] m_period, m_cnt;
    logic m_sync;
    logic [NCH-1:0] m_inv, m_dq;
    logic [CW-1:0] m_start [NCH];
    logic [CW-1:0] m_stop  [NCH];
    logic [CW-1:0] m_sact  [NCH];
    logic [CW-1:0] m_pact  [NCH];
    logic [CW-1:0] m_acc   [NCH];

    function automatic logic [CW-1:0] eff_start(int c);
        return (BUFM[c] && m_sync) ? m_sact[c] : m_start[c];
    endfunction

    function automatic logic [CW-1:0] eff_stop(int c);
        return (BUFM[c] && m_sync) ? m_pact[c] : m_stop[c];
    endfunction

    function automatic logic exp_out(int c);
        logic r;
        if (DENM[c]) r = m_dq[c];
        else         r = (m_cnt >= eff_start(c)) && (m_cnt < eff_stop(c));
        return r ^ m_inv[c];
    endfunction

    function automatic logic [31:0] exp_read(logic [AW-1:0] a);
        int w = int'(a[AW-1:2]);
        logic [31:0] v = '0;
        if (w == 0) v[CW-1:0] = m_period;
        else if (w == 1) v[0] = m_sync;
        else if (w == 2) v[NCH-1:0] = m_inv;
        else if (w >= 4 && w < 4 + 2 * NCH) begin
            if (w[0]) v[CW-1:0] = m_stop[(w - 4) >> 1];
            else      v[CW-1:0] = m_start[(w - 4) >> 1];
        end
        return v;
    endfunction

    // Advance the reference model on each clock edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_period <= '1; m_cnt <= '0; m_sync <= 1'b0; m_inv <= '0; m_dq <= '0;
            for (int c = 0; c < NCH; c++) begin
                m_start[c] <= '0; m_stop[c] <= '0; m_sact[c] <= '0;
                m_pact[c] <= '0; m_acc[c] <= '0;
            end
        end else begin
            m_cnt <= (m_cnt >= m_period) ? '0 : m_cnt + 1'b1;
            for (int c = 0; c < NCH; c++) begin
                logic [CW:0] s;
                if (!m_sync || m_cnt >= m_period) begin
                    m_sact[c] <= m_start[c];
                    m_pact[c] <= m_stop[c];
                end
                s = {1'b0, m_acc[c]} + {1'b0, eff_start(c)};
                m_acc[c] <= s[CW-1:0];
                m_dq[c]  <= s[CW];
            end
            if (psel && penable && pwrite) begin
                int w;
                w = int'(paddr[AW-1:2]);
                if (w == 0) m_period <= pwdata[CW-1:0];
                else if (w == 1) m_sync <= pwdata[0];
                else if (w == 2) m_inv <= pwdata[NCH-1:0];
                else if (w >= 4 && w < 4 + 2 * NCH) begin
                    if (w[0]) m_stop[(w - 4) >> 1]  <= pwdata[CW-1:0];
                    else      m_start[(w - 4) >> 1] <= pwdata[CW-1:0];
                end
            end
        end
    end

    task automatic check(bit ok, string req, string what, longint act, longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Compare every output against the model in the middle of each cycle.
    always @(negedge clk) begin
        #1;
        if (cmp_on && rst_n) begin
            for (int c = 0; c < NCH; c++) begin
                string req;
                if (DENM[c])                 req = "R9";
                else if (!BUFM[c])           req = "R6";
                else if (m_sync)             req = "R7";
                else                         req = "R8";
                if (pwm_out[c] !== exp_out(c))
                    check(1'b0, req, $sformatf("ch%0d output", c), pwm_out[c], exp_out(c));
                else
                    check(1'b1, req, "", 0, 0);
            end
        end
    end

    task automatic bus_write(int word, logic [31:0] data);
        @(negedge clk);
        psel = 1'b1; pwrite = 1'b1; penable = 1'b0;
        paddr = AW'(word * 4); pwdata = data;
        @(negedge clk);
        penable = 1'b1;
        @(negedge clk);
        psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
    endtask

    task automatic bus_read(int word, string req, output logic [31:0] got);
        @(negedge clk);
        psel = 1'b1; pwrite = 1'b0; penable = 1'b0; paddr = AW'(word * 4);
        @(negedge clk);
        penable = 1'b1;
        #2;
        got = prdata;
        check(got === exp_read(paddr), req, $sformatf("read word %0d", word), got, exp_read(paddr));
        @(negedge clk);
        psel = 1'b0; penable = 1'b0;
    endtask

    task automatic count_high(int ch, int cycles, output int highs);
        highs = 0;
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk); #2;
            if (pwm_out[ch]) highs++;
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        logic [31:0] rd;
        int highs, gap;
        void'($urandom(32'd24681));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #2;
        // R1: reset state
        check(pwm_out === '0, "R1", "outputs after reset", pwm_out, 0);
        bus_read(0, "R1", rd);
        check(rd === 32'h0000_00FF, "R1", "period reset", rd, 32'hFF);
        bus_read(1, "R1", rd);
        check(rd === 32'h0, "R1", "control reset", rd, 0);
        bus_read(5, "R1", rd);
        check(rd === 32'h0, "R1", "stop edge reset", rd, 0);
        cmp_on = 1'b1;

        // R2: field widths and unmapped words
        bus_write(0, 32'h0000_03AB);
        bus_read(0, "R2", rd);
        check(rd === 32'h0000_00AB, "R2", "period truncated", rd, 32'hAB);
        bus_read(3, "R2", rd);
        check(rd === 32'h0, "R2", "gap word", rd, 0);
        bus_read(12, "R2", rd);
        check(rd === 32'h0, "R2", "past last channel", rd, 0);
        bus_write(2, 32'hFFFF_FFF0);
        bus_read(2, "R2", rd);
        check(rd === 32'h0, "R2", "invert upper bits dropped", rd, 0);

        // R3: period repeat interval via ch0 pulse at count 0
        bus_write(0, 9);
        bus_write(4, 0);
        bus_write(5, 1);
        do begin @(negedge clk); #2; end while (!pwm_out[0]);
        gap = 0;
        do begin @(negedge clk); #2; gap++; end while (!pwm_out[0]);
        check(gap == 10, "R3", "pulse repeat interval", gap, 10);

        // R4: empty window never high
        bus_write(4, 5);
        bus_write(5, 5);
        count_high(0, 30, highs);
        check(highs == 0, "R4", "start equals stop", highs, 0);

        // R5: invert of empty window is always high
        bus_write(2, 1);
        count_high(0, 30, highs);
        check(highs == 30, "R5", "inverted empty window", highs, 30);
        bus_write(2, 0);

        // R9: density exactness on unbuffered density channel
        bus_write(8, 77);
        repeat (2) @(negedge clk);
        count_high(2, 256, highs);
        check(highs == 77, "R9", "density over 256 cycles", highs, 77);
        bus_write(8, 0);
        repeat (2) @(negedge clk);
        count_high(2, 40, highs);
        check(highs == 0, "R9", "density zero", highs, 0);

        // R10: stop register and period do not affect density channel
        bus_write(8, 200);
        bus_write(9, 13);
        bus_write(0, 3);
        repeat (2) @(negedge clk);
        count_high(2, 256, highs);
        check(highs == 200, "R10", "density with stop/period changed", highs, 200);

        // R7: buffered ch1 in sync mode, long period, mid-period rewrite
        bus_write(0, 49);
        bus_write(6, 10);
        bus_write(7, 40);
        bus_write(1, 1);
        repeat (60) @(negedge clk);
        bus_write(6, 0);
        bus_write(7, 5);
        repeat (120) @(negedge clk);
        // R8: clear sync, immediate updates on ch1
        bus_write(1, 0);
        bus_write(6, 20);
        bus_write(7, 30);
        repeat (60) @(negedge clk);

        // Random mixed traffic
        for (int it = 0; it < 2500; it++) begin
            int op = int'($urandom_range(0, 9));
            if (op < 5) begin
                int ch = int'($urandom_range(0, NCH - 1));
                bus_write(4 + 2 * ch + int'($urandom_range(0, 1)), $urandom_range(0, 255));
            end else if (op == 5) begin
                bus_write(0, $urandom_range(3, 40));
            end else if (op == 6) begin
                bus_write(1, $urandom_range(0, 1));
            end else if (op == 7) begin
                bus_write(2, $urandom);
            end else begin
                bus_read(int'($urandom_range(0, 15)), "R2", rd);
            end
            repeat (int'($urandom_range(0, 6))) @(negedge clk);
        end

        cmp_on = 1'b0;
        if (!finished) begin
            finished = 1'b1;
            summary();
            $finish;
        end
    end
endmodule